// File: doc/BRIEF.md
# Multi-Mode Compare Timer with PWM Outputs

This block is a 16-bit counter that advances on prescaled ticks taken from one of four tick inputs. Four counting behaviours are available: halted, counting up to a period value and restarting, free-running across the full range, and counting up to the period and back down to zero. Compare register 0 holds the period. Compare channels 1 and 2 each raise their own pending flag when the counter lands on their value. Each of those channels also drives a PWM pin in reset/set fashion: the pin drops at the channel's own match and rises at the period match, so a duty cycle is produced with no software involvement.

Software reaches the block through a small register port. Writes take effect at the clock edge. Reads are combinational and never stall. The port is always ready, so it has no back-pressure and no handshake beyond the write and read strobes. A read of the vector register returns a code for the most urgent enabled pending event and clears only that event's flag. An interrupt line is high while any enabled event is pending.

Top module: `cmp_pwm_timer`

## Requirements
- R1: Register addresses are fixed. 0 is control, 1 is the counter (readable, and writable to load it directly), 2, 3 and 4 are compare registers 0, 1 and 2, 5 is channel control, and 6 is the vector register. After reset every register reads 0, both PWM pins are 0 and the interrupt line is 0.
- R2: Control bits 9:8 select which tick input advances the timer: 00 selects input 0, 01 input 1, 10 input 2 and 11 input 3. Pulses on the unselected inputs have no effect on the counter.
- R3: Control bits 7:6 divide the selected ticks by 1, 2, 4 or 8 for the codes 00, 01, 10 and 11.
- R4: Control bits 5:4 equal to 00 halt the counter, and the counter value is held.
- R5: Mode 01 counts from 0 up to compare 0, then moves to 0 on the next tick. A count at or above compare 0 also moves to 0 on the next tick.
- R6: Mode 10 counts from 0 to 0xFFFF and wraps to 0.
- R7: Mode 11 counts up to compare 0 and then back down to 0, and keeps repeating that cycle.
- R8: Control bit 0 is the overflow flag. It is set when the counter wraps to 0 in mode 01 or mode 10, and when the count reaches 0 in mode 11. Software can write it. Control bit 1 is its interrupt enable.
- R9: Writing 1 to control bit 2 resets the counter, the prescaler and the count direction. Bit 2 always reads as 0.
- R10: Channel control bits 8 and 9 are the pending flags of channels 1 and 2. A flag is set on the tick where the counter becomes equal to that channel's compare register. Bits 0 and 1 are the matching interrupt enables.
- R11: PWM pin k-1 belongs to channel k. It goes to 0 when the counter becomes equal to compare k and goes to 1 when the counter becomes equal to compare 0. When both happen on the same tick, the 0 wins.
- R12: A read of the vector register returns 2 for channel 1, 4 for channel 2 and 10 for overflow. Only enabled pending events count, and the lowest code is reported first. The read returns 0 when no enabled event is pending. The read clears only the reported flag.
- R13: The interrupt line is high exactly while the vector register would read a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Tick strobes of the four selectable timer sources, synchronous to clk |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, committed at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; only matters at the vector address, where it clears the reported flag |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| pwm_out | output | 2 | Reset/set PWM outputs of channels 1 and 2 |
| irq | output | 1 | Interrupt request |

## Verification
The counting function is exercised with a period of 5 in mode 01 and a period of 4 in mode 11, which separates the restart-at-period behaviour from the turn-around-and-descend behaviour. A preload just below 0xFFFF is run in mode 10 to separate a full-range wrap from a period-limited one. A divide-by-4 run started with the clear bit, compared against an exact tick count, shows whether the prescaler phase resets. Several duty patterns are measured at the PWM pins: periods of 16 and 512, plus a compare equal to the period, which tells apart the rule of reset winning over set. Vector reads with all three events pending, and again with a masked one, separate the priority order from flag clearing and masking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_STOP = 2'b00,
    MD_UP   = 2'b01,
    MD_CONT = 2'b10,
    MD_UPDN = 2'b11
  } tmr_mode_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CNT  = 1;
  localparam int unsigned A_CMP0 = 2;

  localparam logic [3:0] OVF_CODE = 4'd10;

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] div;
    tmr_mode_e  mode;
    logic       ovf_ie;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  input  logic             clr,
  output logic             tick
);
  localparam int unsigned PW = (1 << DIV_W) - 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb begin
    lim  = (PW'(1) << div) - PW'(1);
    tick = run && src_tick && (pcnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (run && src_tick) begin
      pcnt <= (pcnt == lim) ? '0 : pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] cmp0,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         step,
  output logic         wrap
);
  logic dir_up;
  logic dir_n;
  logic wrap_c;

  always_comb begin
    nxt    = cnt;
    dir_n  = dir_up;
    wrap_c = 1'b0;
    unique case (mode)
      MD_UP: begin
        if (cnt >= cmp0) begin
          nxt    = '0;
          wrap_c = 1'b1;
        end else begin
          nxt = cnt + W'(1);
        end
      end
      MD_CONT: begin
        nxt    = cnt + W'(1);
        wrap_c = (cnt == '1);
      end
      MD_UPDN: begin
        if (dir_up) begin
          if (cmp0 == '0) begin
            nxt = '0;
          end else if (cnt >= cmp0) begin
            if (cnt <= W'(1)) begin
              nxt    = '0;
              wrap_c = 1'b1;
            end else begin
              nxt   = cnt - W'(1);
              dir_n = 1'b0;
            end
          end else begin
            nxt = cnt + W'(1);
          end
        end else begin
          if (cnt <= W'(1)) begin
            nxt    = '0;
            dir_n  = 1'b1;
            wrap_c = 1'b1;
          end else begin
            nxt = cnt - W'(1);
          end
        end
      end
      default: begin
        nxt = cnt;
      end
    endcase
  end

  assign step = tick && (mode != MD_STOP) && !clr && !ld;
  assign wrap = step && wrap_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (clr) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (step) begin
      cnt    <= nxt;
      dir_up <= dir_n;
    end
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] cmp,
  input  logic         per_hit,
  input  logic         sw_wr,
  input  logic         sw_val,
  input  logic         vec_clr,
  output logic         flag,
  output logic         pwm
);
  logic hit;

  assign hit = step && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pwm  <= 1'b0;
    end else begin
      if (hit) begin
        flag <= 1'b1;
      end else if (sw_wr) begin
        flag <= sw_val;
      end else if (vec_clr) begin
        flag <= 1'b0;
      end
      if (hit) begin
        pwm <= 1'b0;
      end else if (per_hit) begin
        pwm <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_vector.sv
module tmr_vector
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH:0] pend,
  output logic [3:0]   code,
  output logic [NCH:0] sel
);
  always_comb begin
    code = '0;
    sel  = '0;
    for (int i = NCH; i >= 0; i--) begin
      if (pend[i]) begin
        code   = (i == NCH) ? OVF_CODE : 4'(2 * (i + 1));
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned NCH   = 2,
  parameter int unsigned NSRC  = 4,
  parameter int unsigned DIV_W = 2,
  parameter int unsigned AW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [W-1:0]    reg_wdata,
  input  logic            reg_rd,
  output logic [W-1:0]    reg_rdata,
  output logic [NCH-1:0]  pwm_out,
  output logic            irq
);
  localparam int unsigned A_CHCTL = A_CMP0 + NCH + 1;
  localparam int unsigned A_VEC   = A_CHCTL + 1;
  localparam int unsigned FLG_LSB = W / 2;

  tmr_ctrl_t       ctrl_q;
  logic            ovf_flag;
  logic [NCH-1:0]  ch_ie;
  logic [NCH-1:0]  ch_flag;
  logic [W-1:0]    cmp_q [NCH+1];

  logic            wr_ctrl, wr_cnt, wr_chctl, clr;
  logic            src_sel, tick;
  logic [W-1:0]    cnt, nxt;
  logic            step, wrap, per_hit;
  logic [NCH:0]    pend, vsel, vec_clr;
  logic [3:0]      vec_code;

  assign wr_ctrl  = reg_wr && (reg_addr == AW'(A_CTRL));
  assign wr_cnt   = reg_wr && (reg_addr == AW'(A_CNT));
  assign wr_chctl = reg_wr && (reg_addr == AW'(A_CHCTL));
  assign clr      = wr_ctrl && reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ch_ie  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.src    <= reg_wdata[9:8];
        ctrl_q.div    <= reg_wdata[7:6];
        ctrl_q.mode   <= tmr_mode_e'(reg_wdata[5:4]);
        ctrl_q.ovf_ie <= reg_wdata[1];
      end
      if (wr_chctl) begin
        ch_ie <= reg_wdata[NCH-1:0];
      end
    end
  end

  for (genvar i = 0; i <= NCH; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[i] <= '0;
      end else if (reg_wr && (reg_addr == AW'(A_CMP0 + i))) begin
        cmp_q[i] <= reg_wdata;
      end
    end
  end

  assign src_sel = src_tick[ctrl_q.src];

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_tick(src_sel),
    .div     (ctrl_q.div),
    .run     (ctrl_q.mode != MD_STOP),
    .clr     (clr),
    .tick    (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .mode  (ctrl_q.mode),
    .cmp0  (cmp_q[0]),
    .clr   (clr),
    .ld    (wr_cnt),
    .ld_val(reg_wdata),
    .cnt   (cnt),
    .nxt   (nxt),
    .step  (step),
    .wrap  (wrap)
  );

  assign per_hit = step && (nxt == cmp_q[0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_cmp_chan #(.W(W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .nxt    (nxt),
      .cmp    (cmp_q[i+1]),
      .per_hit(per_hit),
      .sw_wr  (wr_chctl),
      .sw_val (reg_wdata[FLG_LSB+i]),
      .vec_clr(vec_clr[i]),
      .flag   (ch_flag[i]),
      .pwm    (pwm_out[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (wrap) begin
      ovf_flag <= 1'b1;
    end else if (wr_ctrl) begin
      ovf_flag <= reg_wdata[0];
    end else if (vec_clr[NCH]) begin
      ovf_flag <= 1'b0;
    end
  end

  assign pend = {ovf_flag && ctrl_q.ovf_ie, ch_flag & ch_ie};

  tmr_vector #(.NCH(NCH)) u_vec (
    .pend(pend),
    .code(vec_code),
    .sel (vsel)
  );

  assign vec_clr = (reg_rd && (reg_addr == AW'(A_VEC))) ? vsel : '0;
  assign irq     = |pend;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) begin
      reg_rdata[9:8] = ctrl_q.src;
      reg_rdata[7:6] = ctrl_q.div;
      reg_rdata[5:4] = ctrl_q.mode;
      reg_rdata[1]   = ctrl_q.ovf_ie;
      reg_rdata[0]   = ovf_flag;
    end else if (reg_addr == AW'(A_CNT)) begin
      reg_rdata = cnt;
    end else if (reg_addr == AW'(A_CHCTL)) begin
      reg_rdata[NCH-1:0]               = ch_ie;
      reg_rdata[FLG_LSB+NCH-1:FLG_LSB] = ch_flag;
    end else if (reg_addr == AW'(A_VEC)) begin
      reg_rdata[3:0] = vec_code;
    end else begin
      for (int i = 0; i <= NCH; i++) begin
        if (reg_addr == AW'(A_CMP0 + i)) reg_rdata = cmp_q[i];
      end
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input tmr_mode_e    mode,
  input logic         step,
  input logic         ld,
  input logic         clr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic         ovf_flag,
  input logic         pwm0,
  input logic         irq,
  input logic [3:0]   vec_code
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STOP && !ld && !clr) |=> $stable(cnt)); // R4

  AST_UP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == MD_UP && cnt >= cmp0) |=> (cnt == '0)); // R5

  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == MD_CONT && cnt == '1) |=> (cnt == '0 && ovf_flag)); // R6

  AST_PWM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && $stable(cmp1) && cnt == cmp1) |-> !pwm0); // R11

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code == 4'd0 || vec_code == 4'd2 || vec_code == 4'd4 || vec_code == 4'd10)); // R12

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_code != 4'd0)); // R13
endmodule

bind cmp_pwm_timer tmr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (ctrl_q.mode),
  .step    (step),
  .ld      (wr_cnt),
  .clr     (clr),
  .cnt     (cnt),
  .cmp0    (cmp_q[0]),
  .cmp1    (cmp_q[1]),
  .ovf_flag(ovf_flag),
  .pwm0    (pwm_out[0]),
  .irq     (irq),
  .vec_code(vec_code)
);

// File: tb/sim_cmp_pwm_timer.sv
module sim_cmp_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic [1:0]  pwm_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] AC = 3'd0, AN = 3'd1, A0 = 3'd2, A1 = 3'd3, A2 = 3'd4, AH = 3'd5, AV = 3'd6;

  always #5 clk = ~clk;

  cmp_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input int src, input int div, input int mode,
                                      input int clr, input int ie, input int flg);
    return 16'((src << 8) | (div << 6) | (mode << 4) | (clr << 2) | (ie << 1) | flg);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd_vec(output int v);
    reg_addr = AV; reg_rd = 1'b1;
    #1;
    v = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    rd(AN, v);  chk(v == 0, "R1 count after reset", v, 0);
    rd(AC, v);  chk(v == 0, "R1 control after reset", v, 0);
    rd(AV, v);  chk(v == 0, "R1 vector after reset", v, 0);
    chk(pwm_out == 0 && irq == 0, "R1 pins after reset", {pwm_out, irq}, 0);
  endtask

  task automatic t_up();
    int prev, cur, exp, v;
    src_tick = 4'b0001;
    wr(A0, 16'd5);
    wr(AC, ctl(0, 0, 1, 1, 0, 0));
    rd(AN, prev);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      rd(AN, cur);
      exp = (prev >= 5) ? 0 : prev + 1;
      chk(cur == exp, "R5 up-mode sequence", cur, exp);
      prev = cur;
    end
    rd(AC, v);
    chk(v[0] == 1'b1, "R8 overflow flag after up wrap", v[0], 1);
  endtask

  task automatic t_updn();
    int prev, cur, exp, v;
    bit up;
    src_tick = 4'b0001;
    wr(A0, 16'd4);
    wr(AC, ctl(0, 0, 3, 1, 0, 0));
    up = 1; prev = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      rd(AN, cur);
      if (up) begin
        if (prev >= 4) begin exp = prev - 1; up = 0; end
        else exp = prev + 1;
      end else begin
        exp = prev - 1;
        if (exp == 0) up = 1;
      end
      chk(cur == exp, "R7 up/down sequence", cur, exp);
      if (k == 4) begin
        rd(AC, v); chk(v[0] == 1'b0, "R8 no overflow before reaching 0", v[0], 0);
      end
      if (k == 8) begin
        rd(AC, v); chk(v[0] == 1'b1, "R8 overflow on reaching 0 in mode 11", v[0], 1);
      end
      prev = cur;
    end
  endtask

  task automatic t_clear();
    int v;
    src_tick = 4'b0001;
    wr(A0, 16'd4);
    wr(AC, ctl(0, 0, 3, 1, 0, 0));
    repeat (6) @(negedge clk);
    rd(AN, v); chk(v == 2, "R7 descending count", v, 2);
    wr(AC, ctl(0, 0, 3, 1, 0, 0));
    rd(AN, v); chk(v == 0, "R9 clear resets counter", v, 0);
    rd(AC, v); chk(v[2] == 1'b0, "R9 clear bit reads 0", v[2], 0);
    @(negedge clk);
    rd(AN, v); chk(v == 1, "R9 clear resets direction to up", v, 1);
  endtask

  task automatic t_cont();
    int v;
    src_tick = 4'b0001;
    wr(AC, ctl(0, 0, 0, 1, 0, 0));
    wr(AN, 16'hFFFD);
    wr(AC, ctl(0, 0, 2, 0, 0, 0));
    rd(AN, v); chk(v == 16'hFFFD, "R1 counter load", v, 16'hFFFD);
    repeat (2) @(negedge clk);
    rd(AN, v); chk(v == 16'hFFFF, "R6 reaches top", v, 16'hFFFF);
    rd(AC, v); chk(v[0] == 1'b0, "R8 no overflow before wrap", v[0], 0);
    @(negedge clk);
    rd(AN, v); chk(v == 0, "R6 wraps to 0", v, 0);
    rd(AC, v); chk(v[0] == 1'b1, "R8 overflow on continuous wrap", v[0], 1);
  endtask

  task automatic t_prescale();
    int v;
    src_tick = 4'b0001;
    wr(A0, 16'd1000);
    wr(AC, ctl(0, 2, 1, 1, 0, 0));
    repeat (40) @(negedge clk);
    rd(AN, v); chk(v == 10, "R3 divide by 4", v, 10);
    wr(AC, ctl(0, 3, 1, 1, 0, 0));
    repeat (64) @(negedge clk);
    rd(AN, v); chk(v == 8, "R3 divide by 8", v, 8);
  endtask

  task automatic t_src_stop();
    int v;
    src_tick = 4'b0001;
    wr(A0, 16'd100);
    wr(AC, ctl(1, 0, 1, 1, 0, 0));
    repeat (10) @(negedge clk);
    rd(AN, v); chk(v == 0, "R2 unselected source ignored", v, 0);
    src_tick = 4'b0000;
    for (int k = 0; k < 3; k++) begin
      src_tick = 4'b0010; @(negedge clk);
      src_tick = 4'b0000; @(negedge clk);
    end
    rd(AN, v); chk(v == 3, "R2 selected source counts", v, 3);
    wr(AC, ctl(1, 0, 0, 0, 0, 0));
    src_tick = 4'b1111;
    repeat (10) @(negedge clk);
    rd(AN, v); chk(v == 3, "R4 stop mode holds", v, 3);
  endtask

  task automatic t_pwm();
    int h1, h2;
    src_tick = 4'b0001;
    wr(A0, 16'd15); wr(A1, 16'd10); wr(A2, 16'd3);
    wr(AC, ctl(0, 0, 1, 1, 0, 0));
    repeat (20) @(negedge clk);
    h1 = 0; h2 = 0;
    for (int k = 0; k < 32; k++) begin
      h1 += pwm_out[0]; h2 += pwm_out[1];
      @(negedge clk);
    end
    chk(h1 == 22, "R11 channel 1 duty 11/16", h1, 22);
    chk(h2 == 8, "R11 channel 2 duty 4/16", h2, 8);
    wr(A1, 16'd15);
    repeat (20) @(negedge clk);
    h1 = 0;
    for (int k = 0; k < 16; k++) begin
      h1 += pwm_out[0];
      @(negedge clk);
    end
    chk(h1 == 0, "R11 reset wins when compare equals period", h1, 0);
    wr(A0, 16'd511); wr(A1, 16'd384);
    wr(AC, ctl(0, 0, 1, 1, 0, 0));
    repeat (600) @(negedge clk);
    h1 = 0;
    for (int k = 0; k < 512; k++) begin
      h1 += pwm_out[0];
      @(negedge clk);
    end
    chk(h1 == 385, "R11 period 512 duty", h1, 385);
  endtask

  task automatic t_cmp_flag();
    int v;
    src_tick = 4'b0001;
    wr(AH, 16'h0000);
    wr(A0, 16'd100); wr(A1, 16'd3);
    wr(AC, ctl(0, 0, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    rd(AH, v); chk(v[8] == 1'b0, "R10 no flag before match", v[8], 0);
    @(negedge clk);
    rd(AH, v); chk(v[8] == 1'b1, "R10 flag on match", v[8], 1);
    chk(irq == 1'b0, "R13 masked flag gives no interrupt", irq, 0);
  endtask

  task automatic t_vector();
    int v;
    wr(AC, ctl(0, 0, 0, 0, 1, 1));
    wr(AH, 16'h0303);
    chk(irq == 1'b1, "R13 interrupt while pending", irq, 1);
    rd_vec(v); chk(v == 2, "R12 channel 1 first", v, 2);
    rd(AH, v); chk(v[9:8] == 2'b10, "R12 read clears only channel 1", v[9:8], 2);
    rd_vec(v); chk(v == 4, "R12 channel 2 next", v, 4);
    rd_vec(v); chk(v == 10, "R12 overflow last", v, 10);
    rd(AC, v); chk(v[0] == 1'b0, "R12 overflow flag cleared", v[0], 0);
    rd_vec(v); chk(v == 0, "R12 nothing pending", v, 0);
    chk(irq == 1'b0, "R13 no interrupt when idle", irq, 0);
    wr(AH, 16'h0100);
    rd_vec(v); chk(v == 0, "R12 disabled flag not reported", v, 0);
    rd(AH, v); chk(v[8] == 1'b1, "R12 disabled flag kept", v[8], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_updn();
    t_clear();
    t_cont();
    t_prescale();
    t_src_stop();
    t_pwm();
    t_cmp_flag();
    t_vector();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule